// File: doc/BRIEF.md
# Repeat-Mode Alarm Comparator

This block watches a running calendar time (seconds, minutes, hours and day of month, all BCD) and raises an alarm when that time agrees with a programmed alarm setting. Four alarm registers hold the alarm second, minute, hour and date. Each one also carries one repeat bit. Together the four repeat bits pick how often the alarm fires: every second, every minute, every hour, every day or once a month. The comparison runs once on each one-second tick, against the time value presented with that tick.

A match sets an alarm flag. When the flag-enable bit is set, the match also pulls an active-low interrupt, and a separate output-enable stands in for an open-drain driver. On battery power the interrupt is further gated by a battery-mode enable. Reading the flags register clears the flag and releases the interrupt.

Software reaches the registers through a small port. An address is captured on a strobe, and later read or write strobes act on that captured address. A match that arrives while the flags address is captured is not lost. It is held back and posted to the flag once a different address is captured.

Top module: `alm_repeat_alarm`

## Requirements
- R1: With repeat code 1111 the flag is set on every tick. With code 1110 it is set on a tick only when the alarm second equals the current second. The code is written RPT4..RPT1, and RPTn is bit 7 of alarm register n (1 = second, 2 = minute, 3 = hour, 4 = date).
- R2: With code 1100 second and minute must both match. With code 1000 second, minute and hour must all match.
- R3: With code 0000 second, minute, hour and date must all match.
- R4: Any code other than 1111, 1110, 1100, 1000 and 0000 behaves as code 1111.
- R5: A match sets AF, bit 6 of the flags register (address 0). The interrupt is active (irq_n = 0, irq_oe = 1) only while AF = 1 and AFE = 1, where AFE is bit 7 of the control register (address 5).
- R6: A read strobe at the flags address clears AF and releases the interrupt. A write strobe at the flags address changes nothing.
- R7: A match on a tick taken while address 0 is captured leaves AF at 0 until a different address has been captured. AF then reads 1 from the next cycle on.
- R8: While on_battery = 1 the interrupt is active only if ABE (control bit 6) and AFE are both 1. AF is set regardless.
- R9: Reset clears AF, AFE, ABE and all alarm registers, and the captured address becomes 7. After reset, a match sets AF but does not drive the interrupt.
- R10: An alarm date register of 00h together with all four repeat bits at 0 disables the alarm, whatever the current time is.
- R11: The time inputs are compared only in a cycle with sec_tick = 1. A matching time with no tick does not set AF.
- R12: addr_ld captures addr_in, and rd_en and wr_en act on the captured address. The register addresses are 0 flags, 1 to 4 alarm second, minute, hour and date, and 5 control. Every other address reads 00h. Alarm and control registers read back what was written, with unused control bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second; compare enable |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD 24-hour |
| now_date | input | 6 | Current day of month, BCD |
| on_battery | input | 1 | 1 while the system runs from the backup cell |
| addr_ld | input | 1 | Capture addr_in as the register address |
| addr_in | input | 3 | Register address to capture |
| wr_en | input | 1 | Write wdata to the captured address |
| rd_en | input | 1 | Read strobe at the captured address (clears AF at address 0) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Contents of the register at the captured address |
| irq_n | output | 1 | Active-low alarm interrupt |
| irq_oe | output | 1 | Drive enable for irq_n (open-drain stand-in) |

## Verification
The hardest case to reach from the ports is a match that lands while the flags address is captured. If that match is dropped, or posted at the wrong moment, a flag read loses it. To reach it, the bench captures address 0, issues a matching tick and then a read strobe. It checks that AF still reads 0 and the interrupt stays off. It then captures another address and confirms that AF appears exactly one cycle later. A behavioural model of the flags, the pending match and the register contents is compared with rdata, irq_n and irq_oe on every cycle. Direct checks against hand-derived values sit on top of that comparison.

// File: rtl/alm_pkg.sv
// Package: shared constants, register addresses and repeat-mode codes for
// the repeat-mode alarm comparator. Assumes byte-wide registers.
package alm_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int RPT_W  = 4;
    localparam int SEC_W  = 7;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DATE_W = 6;
    localparam int NALM   = 4;

    // bit positions software relies on
    localparam int RPT_BIT = 7;   // repeat bit in each alarm register
    localparam int AF_BIT  = 6;   // alarm flag in the flags register
    localparam int AFE_BIT = 7;   // flag enable in the control register
    localparam int ABE_BIT = 6;   // battery-mode enable in the control register

    typedef enum logic [ADDR_W-1:0] {
        RA_FLAGS = 3'd0,
        RA_ASEC  = 3'd1,
        RA_AMIN  = 3'd2,
        RA_AHOUR = 3'd3,
        RA_ADATE = 3'd4,
        RA_CTRL  = 3'd5,
        RA_IDLE  = 3'd7
    } reg_addr_e;

    // repeat code, written RPT4..RPT1
    typedef enum logic [RPT_W-1:0] {
        RPT_SECOND = 4'b1111,
        RPT_MINUTE = 4'b1110,
        RPT_HOUR   = 4'b1100,
        RPT_DAY    = 4'b1000,
        RPT_MONTH  = 4'b0000
    } rpt_code_e;
endpackage

// File: rtl/alm_regs.sv
// Module: alm_regs
// Holds the captured register address, the four alarm registers and the
// control bits, and drives the read-data mux. The flags register itself
// lives in alm_flags; its AF bit is brought in for the read mux.
// Assumes addresses 1..4 map to alarm registers 0..3 in order.
module alm_regs
    import alm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_ld,
    input  logic [AW-1:0]     addr_in,
    input  logic              wr_en,
    input  logic [DW-1:0]     wdata,
    input  logic              af,
    output logic [AW-1:0]     addr_q,
    output logic [RPT_W-1:0]  rpt_code,
    output logic [SEC_W-1:0]  a_sec,
    output logic [MIN_W-1:0]  a_min,
    output logic [HOUR_W-1:0] a_hour,
    output logic [DATE_W-1:0] a_date,
    output logic              alarm_off,
    output logic              afe,
    output logic              abe,
    output logic [DW-1:0]     rdata
);
    localparam logic [AW-1:0] ADDR_RST = AW'(RA_IDLE);

    logic [DW-1:0] alm_q [NALM];

    // Address capture: addr_ld loads addr_in, reset parks on an unused slot.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= ADDR_RST;
        else if (addr_ld) addr_q <= addr_in;
    end

    // One register per alarm field; the repeat bit is bit RPT_BIT of each.
    for (genvar i = 0; i < NALM; i++) begin : g_alm
        localparam logic [AW-1:0] MY_ADDR = AW'(i + 1);
        // Alarm register i: written when its address is captured.
        always_ff @(posedge clk) begin
            if (!rst_n)                          alm_q[i] <= '0;
            else if (wr_en && addr_q == MY_ADDR) alm_q[i] <= wdata;
        end
        assign rpt_code[i] = alm_q[i][RPT_BIT];
    end

    // Control register: flag enable and battery-mode enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            afe <= 1'b0;
            abe <= 1'b0;
        end else if (wr_en && addr_q == RA_CTRL) begin
            afe <= wdata[AFE_BIT];
            abe <= wdata[ABE_BIT];
        end
    end

    // Field slices for the comparator.
    assign a_sec     = alm_q[0][SEC_W-1:0];
    assign a_min     = alm_q[1][MIN_W-1:0];
    assign a_hour    = alm_q[2][HOUR_W-1:0];
    assign a_date    = alm_q[3][DATE_W-1:0];
    assign alarm_off = (rpt_code == RPT_MONTH) && (alm_q[3] == '0);

    // Read mux over the captured address.
    always_comb begin
        rdata = '0;
        case (addr_q)
            RA_FLAGS: rdata[AF_BIT] = af;
            RA_ASEC:  rdata = alm_q[0];
            RA_AMIN:  rdata = alm_q[1];
            RA_AHOUR: rdata = alm_q[2];
            RA_ADATE: rdata = alm_q[3];
            RA_CTRL: begin
                rdata[AFE_BIT] = afe;
                rdata[ABE_BIT] = abe;
            end
            default:  rdata = '0;
        endcase
    end

    // R9: a reset cycle leaves control bits and alarm settings cleared
    a_r9_reset_clears_ctrl: assert property (@(posedge clk)
        !rst_n |=> (!afe && !abe && alarm_off && addr_q == ADDR_RST));
endmodule

// File: rtl/alm_match.sv
// Module: alm_match
// Decodes the four repeat bits into a compare mode and reports whether the
// current BCD time satisfies the alarm. Purely combinational; the clock is
// used only by the assertions. Assumes both sides use the same BCD coding.
module alm_match
    import alm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RPT_W-1:0]  rpt_code,
    input  logic [SEC_W-1:0]  a_sec,
    input  logic [MIN_W-1:0]  a_min,
    input  logic [HOUR_W-1:0] a_hour,
    input  logic [DATE_W-1:0] a_date,
    input  logic              alarm_off,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [DATE_W-1:0] now_date,
    output logic              hit
);
    logic sec_eq, min_eq, hour_eq, date_eq;
    logic known_code;

    // Per-field equality.
    always_comb begin
        sec_eq  = (a_sec  == now_sec);
        min_eq  = (a_min  == now_min);
        hour_eq = (a_hour == now_hour);
        date_eq = (a_date == now_date);
    end

    // Mode decode: undefined codes fall back to every-second.
    always_comb begin
        known_code = 1'b1;
        case (rpt_code)
            RPT_SECOND: hit = 1'b1;
            RPT_MINUTE: hit = sec_eq;
            RPT_HOUR:   hit = sec_eq && min_eq;
            RPT_DAY:    hit = sec_eq && min_eq && hour_eq;
            RPT_MONTH:  hit = sec_eq && min_eq && hour_eq && date_eq && !alarm_off;
            default: begin
                hit        = 1'b1;
                known_code = 1'b0;
            end
        endcase
    end

    // R1: code 1111 matches on every evaluation
    a_r1_second_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_code == 4'b1111) |-> hit);
    // R4: codes outside the defined set act like once per second
    a_r4_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        !known_code |-> hit);
    // R10: a zero date register with all repeat bits clear never matches
    a_r10_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_off |-> !hit);
endmodule

// File: rtl/alm_flags.sv
// Module: alm_flags
// Owns the alarm flag, the held-off match and the interrupt gating.
// A tick with a match sets AF, unless the flags address is captured, in
// which case the match waits until another address is captured. A read of
// the flags address clears AF. Assumes tick is a single-cycle pulse.
module alm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic at_flags,
    input  logic rd_en,
    input  logic afe,
    input  logic abe,
    input  logic on_battery,
    output logic af,
    output logic irq_n,
    output logic irq_oe
);
    logic af_q, pend_q, irq_act;

    // Flag and pending-match state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (rd_en && at_flags) af_q <= 1'b0;
            if (tick && hit) begin
                if (at_flags) pend_q <= 1'b1;
                else          af_q   <= 1'b1;
            end
            if (pend_q && !at_flags) begin
                af_q   <= 1'b1;
                pend_q <= 1'b0;
            end
        end
    end

    // Interrupt gating: flag enable always, battery enable on backup power.
    assign irq_act = af_q && afe && (!on_battery || abe);
    assign irq_n   = !irq_act;
    assign irq_oe  = irq_act;
    assign af      = af_q;

    // R6: a flags read leaves AF clear afterwards
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at_flags) |=> !af_q);
    // R7: AF cannot rise while the flags address stays captured
    a_r7_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
        (at_flags && !af_q) |=> !af_q);
    // R7: a held match posts once another address is captured
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !at_flags) |=> af_q);
    // R5: the interrupt is never active without AF and AFE
    a_r5_irq_needs_af: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> (af_q && afe));
    // R8: on battery without ABE the interrupt stays released
    a_r8_battery_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (on_battery && !abe) |-> (irq_n && !irq_oe));
endmodule

// File: rtl/alm_repeat_alarm.sv
// Module: alm_repeat_alarm (top)
// Repeat-mode alarm comparator: register port, comparator and flag logic.
// Assumes the time inputs are stable and valid whenever sec_tick is high.
module alm_repeat_alarm
    import alm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [SEC_W-1:0]  now_sec,
    input  logic [MIN_W-1:0]  now_min,
    input  logic [HOUR_W-1:0] now_hour,
    input  logic [DATE_W-1:0] now_date,
    input  logic              on_battery,
    input  logic              addr_ld,
    input  logic [AW-1:0]     addr_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq_n,
    output logic              irq_oe
);
    logic [AW-1:0]     addr_q;
    logic [RPT_W-1:0]  rpt_code;
    logic [SEC_W-1:0]  a_sec;
    logic [MIN_W-1:0]  a_min;
    logic [HOUR_W-1:0] a_hour;
    logic [DATE_W-1:0] a_date;
    logic              alarm_off, afe, abe, af, hit, at_flags;

    assign at_flags = (addr_q == RA_FLAGS);

    alm_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
        .wr_en(wr_en), .wdata(wdata), .af(af), .addr_q(addr_q),
        .rpt_code(rpt_code), .a_sec(a_sec), .a_min(a_min), .a_hour(a_hour),
        .a_date(a_date), .alarm_off(alarm_off), .afe(afe), .abe(abe),
        .rdata(rdata)
    );

    alm_match u_match (
        .clk(clk), .rst_n(rst_n), .rpt_code(rpt_code), .a_sec(a_sec),
        .a_min(a_min), .a_hour(a_hour), .a_date(a_date),
        .alarm_off(alarm_off), .now_sec(now_sec), .now_min(now_min),
        .now_hour(now_hour), .now_date(now_date), .hit(hit)
    );

    alm_flags u_flags (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .hit(hit),
        .at_flags(at_flags), .rd_en(rd_en), .afe(afe), .abe(abe),
        .on_battery(on_battery), .af(af), .irq_n(irq_n), .irq_oe(irq_oe)
    );
endmodule

// File: tb/alm_repeat_alarm_tb.sv
`timescale 1ns/1ps
module alm_repeat_alarm_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] now_sec = '0;
    logic [6:0] now_min = '0;
    logic [5:0] now_hour = '0;
    logic [5:0] now_date = '0;
    logic       on_battery = 1'b0;
    logic       addr_ld = 1'b0;
    logic [2:0] addr_in = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n, irq_oe;

    int    tests = 0;
    int    fails = 0;
    bit    done  = 0;
    string cur_req = "R9";

    // reference model state
    int         m_addr;
    logic [7:0] m_alm [4];
    bit         m_afe, m_abe, m_af, m_pend;

    always #2 clk = ~clk;

    alm_repeat_alarm u_dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_sec(now_sec),
        .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .on_battery(on_battery), .addr_ld(addr_ld), .addr_in(addr_in),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .irq_n(irq_n), .irq_oe(irq_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // alarm decision from the requirement text
    function automatic bit m_hit();
        logic [3:0] code;
        bit s, mi, h, d;
        code = {m_alm[3][7], m_alm[2][7], m_alm[1][7], m_alm[0][7]};
        s  = (m_alm[0][6:0] == now_sec);
        mi = (m_alm[1][6:0] == now_min);
        h  = (m_alm[2][5:0] == now_hour);
        d  = (m_alm[3][5:0] == now_date);
        if (code == 4'b1111)      return 1;
        else if (code == 4'b1110) return s;
        else if (code == 4'b1100) return s && mi;
        else if (code == 4'b1000) return s && mi && h;
        else if (code == 4'b0000) return (m_alm[3] != 8'h00) && s && mi && h && d;
        else                      return 1;
    endfunction

    task automatic model_step();
        bit h, at, n_af, n_pend;
        if (!rst_n) begin
            m_addr = 7; m_afe = 0; m_abe = 0; m_af = 0; m_pend = 0;
            for (int i = 0; i < 4; i++) m_alm[i] = 8'h00;
            return;
        end
        h = m_hit();
        at = (m_addr == 0);
        n_af = m_af; n_pend = m_pend;
        if (rd_en && at) n_af = 0;
        if (sec_tick && h) begin
            if (at) n_pend = 1; else n_af = 1;
        end
        if (m_pend && !at) begin n_af = 1; n_pend = 0; end
        if (wr_en) begin
            if (m_addr >= 1 && m_addr <= 4) m_alm[m_addr-1] = wdata;
            else if (m_addr == 5) begin m_afe = wdata[7]; m_abe = wdata[6]; end
        end
        if (addr_ld) m_addr = int'(addr_in);
        m_af = n_af; m_pend = n_pend;
    endtask

    task automatic model_cmp();
        logic [7:0] e_rd;
        bit e_irq;
        case (m_addr)
            0:          e_rd = {1'b0, m_af, 6'b0};
            1, 2, 3, 4: e_rd = m_alm[m_addr-1];
            5:          e_rd = {m_afe, m_abe, 6'b0};
            default:    e_rd = 8'h00;
        endcase
        e_irq = m_af && m_afe && (!on_battery || m_abe);
        chk(cur_req, "rdata vs model", rdata, e_rd);
        chk(cur_req, "irq_n vs model", irq_n, !e_irq);
        chk(cur_req, "irq_oe vs model", irq_oe, e_irq);
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge
    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        model_cmp();
        addr_ld = 0; wr_en = 0; rd_en = 0; sec_tick = 0;
    endtask

    task automatic latch(input logic [2:0] a);
        addr_ld = 1; addr_in = a; cyc();
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        latch(a);
        wr_en = 1; wdata = d; cyc();
    endtask

    task automatic set_alarm(input logic [7:0] s, input logic [7:0] mi,
                             input logic [7:0] h, input logic [7:0] d);
        wreg(3'd1, s); wreg(3'd2, mi); wreg(3'd3, h); wreg(3'd4, d);
        latch(3'd7);
    endtask

    task automatic tick(input logic [6:0] s, input logic [6:0] mi,
                        input logic [5:0] h, input logic [5:0] d);
        now_sec = s; now_min = mi; now_hour = h; now_date = d;
        sec_tick = 1; cyc();
    endtask

    // inspect AF, clear it by a read, park the address away from flags
    task automatic peek(input logic [7:0] exp, input string req);
        latch(3'd0);
        chk(req, "flags value", rdata, exp);
        rd_en = 1; cyc();
        chk(req, "flags after read", rdata, 8'h00);
        chk(req, "irq released after read", irq_n, 1'b1);
        latch(3'd7);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        cur_req = "R9";
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk("R9", "irq_n after reset", irq_n, 1'b1);
        chk("R9", "irq_oe after reset", irq_oe, 1'b0);
        chk("R9", "idle address reads", rdata, 8'h00);
        latch(3'd5);
        chk("R9", "control after reset", rdata, 8'h00);
        latch(3'd4);
        chk("R9", "alarm date after reset", rdata, 8'h00);

        // R12: register map read-back
        cur_req = "R12";
        wreg(3'd1, 8'h25); chk("R12", "alarm sec readback", rdata, 8'h25);
        wreg(3'd2, 8'h47); chk("R12", "alarm min readback", rdata, 8'h47);
        wreg(3'd3, 8'h63); chk("R12", "alarm hour readback", rdata, 8'h63);
        wreg(3'd4, 8'h31); chk("R12", "alarm date readback", rdata, 8'h31);
        wreg(3'd5, 8'hFF); chk("R12", "control readback", rdata, 8'hC0);
        wreg(3'd6, 8'hAA); chk("R12", "unused address", rdata, 8'h00);
        wreg(3'd5, 8'h00);
        set_alarm(8'h00, 8'h00, 8'h00, 8'h00);

        // R1: every second, then seconds match
        cur_req = "R1";
        set_alarm(8'h92, 8'h80, 8'h80, 8'h80);
        wreg(3'd5, 8'h80);
        latch(3'd7);
        tick(7'h05, 7'h10, 6'h03, 6'h04);
        chk("R1", "every-second irq_n", irq_n, 1'b0);
        chk("R1", "every-second irq_oe", irq_oe, 1'b1);
        peek(8'h40, "R1");
        set_alarm(8'h30, 8'h80, 8'h80, 8'h80);
        tick(7'h29, 7'h10, 6'h03, 6'h04);
        chk("R1", "minute mode, wrong second", irq_n, 1'b1);
        tick(7'h30, 7'h11, 6'h05, 6'h06);
        chk("R1", "minute mode, second matches", irq_n, 1'b0);
        peek(8'h40, "R1");

        // R2: hourly and daily
        cur_req = "R2";
        set_alarm(8'h00, 8'h15, 8'h87, 8'h80);
        tick(7'h00, 7'h16, 6'h07, 6'h01);
        chk("R2", "hour mode, wrong minute", irq_n, 1'b1);
        tick(7'h00, 7'h15, 6'h08, 6'h01);
        chk("R2", "hour mode, hour ignored", irq_n, 1'b0);
        peek(8'h40, "R2");
        set_alarm(8'h00, 8'h15, 8'h07, 8'h80);
        tick(7'h00, 7'h15, 6'h08, 6'h01);
        chk("R2", "day mode, wrong hour", irq_n, 1'b1);
        tick(7'h00, 7'h15, 6'h07, 6'h09);
        chk("R2", "day mode, full match", irq_n, 1'b0);
        peek(8'h40, "R2");

        // R3: monthly
        cur_req = "R3";
        set_alarm(8'h00, 8'h15, 8'h07, 8'h12);
        tick(7'h00, 7'h15, 6'h07, 6'h11);
        chk("R3", "month mode, wrong date", irq_n, 1'b1);
        tick(7'h00, 7'h15, 6'h07, 6'h12);
        chk("R3", "month mode, all match", irq_n, 1'b0);
        peek(8'h40, "R3");

        // R4: undefined code 0001 and 1010 act as every second
        cur_req = "R4";
        set_alarm(8'hD9, 8'h00, 8'h00, 8'h00);
        tick(7'h01, 7'h02, 6'h03, 6'h04);
        chk("R4", "code 0001 fires", irq_n, 1'b0);
        peek(8'h40, "R4");
        set_alarm(8'h59, 8'h80, 8'h00, 8'h80);
        tick(7'h01, 7'h02, 6'h03, 6'h04);
        chk("R4", "code 1010 fires", irq_n, 1'b0);
        peek(8'h40, "R4");

        // R5: AFE gates the interrupt, not the flag
        cur_req = "R5";
        wreg(3'd5, 8'h00);
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        chk("R5", "AF set but AFE=0 irq_n", irq_n, 1'b1);
        chk("R5", "AF set but AFE=0 irq_oe", irq_oe, 1'b0);
        wreg(3'd5, 8'h80);
        chk("R5", "AFE raised with AF pending irq_n", irq_n, 1'b0);
        peek(8'h40, "R5");

        // R6: writes to flags are ignored
        cur_req = "R6";
        wreg(3'd0, 8'hFF);
        chk("R6", "flags write with AF clear", rdata, 8'h00);
        chk("R6", "flags write irq", irq_n, 1'b1);
        latch(3'd7);
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        wreg(3'd0, 8'h00);
        chk("R6", "flags write keeps AF", rdata, 8'h40);
        chk("R6", "flags write keeps irq", irq_n, 1'b0);
        rd_en = 1; cyc();
        chk("R6", "read clears AF", rdata, 8'h00);
        chk("R6", "read releases irq", irq_oe, 1'b0);
        latch(3'd7);

        // R7: match held off while flags address captured
        cur_req = "R7";
        latch(3'd0);
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        chk("R7", "held match not visible", rdata, 8'h00);
        chk("R7", "held match no irq", irq_n, 1'b1);
        rd_en = 1; cyc();
        chk("R7", "read does not lose held match", rdata, 8'h00);
        latch(3'd1);
        chk("R7", "not yet posted at capture edge", irq_n, 1'b1);
        cyc();
        chk("R7", "posted one cycle after capture", irq_n, 1'b0);
        peek(8'h40, "R7");

        // R8: battery mode needs ABE
        cur_req = "R8";
        on_battery = 1;
        cyc();
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        chk("R8", "battery without ABE irq_n", irq_n, 1'b1);
        chk("R8", "battery without ABE irq_oe", irq_oe, 1'b0);
        wreg(3'd5, 8'hC0);
        chk("R8", "battery with ABE and AFE", irq_n, 1'b0);
        on_battery = 0;
        cyc();
        chk("R8", "main power with AFE", irq_n, 1'b0);
        peek(8'h40, "R8");

        // R9: alarm right after reset sets only AF
        cur_req = "R9";
        rst_n = 0; cyc(); cyc();
        rst_n = 1; cyc();
        latch(3'd5);
        chk("R9", "control cleared by reset", rdata, 8'h00);
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        tick(7'h00, 7'h00, 6'h00, 6'h01);
        chk("R9", "post-reset alarm no irq", irq_n, 1'b1);
        peek(8'h40, "R9");

        // R10: zero date with all repeat bits clear disables the alarm
        cur_req = "R10";
        wreg(3'd5, 8'h80);
        set_alarm(8'h00, 8'h00, 8'h00, 8'h00);
        tick(7'h00, 7'h00, 6'h00, 6'h00);
        tick(7'h12, 7'h34, 6'h05, 6'h06);
        chk("R10", "disabled alarm irq", irq_n, 1'b1);
        peek(8'h00, "R10");

        // R11: only ticked cycles compare
        cur_req = "R11";
        set_alarm(8'h20, 8'h80, 8'h80, 8'h80);
        now_sec = 7'h20;
        repeat (5) cyc();
        chk("R11", "matching time without tick", irq_n, 1'b1);
        peek(8'h00, "R11");
        tick(7'h20, 7'h00, 6'h00, 6'h01);
        chk("R11", "matching time with tick", irq_n, 1'b0);
        peek(8'h40, "R11");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule